// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the three active-low control strobes of an SDRAM command bus (row strobe, column strobe and write enable) together with the bank select, and classifies every sampled clock edge as an activate, read, write, precharge, auto refresh or a command it does not track. It keeps an open/closed state and a row-to-column delay timer for each bank, and only reports a read or write as legal when the addressed bank is open and its delay has run out.

Refresh is accepted only when every bank is closed; each accepted refresh advances an internal row counter that wraps to zero. Illegal column commands and illegal refreshes are rejected and flagged with a one-clock error pulse instead of a strobe. All strobes, error flags and the reported bank are registered: they appear in the cycle that follows the clock edge at which the command was sampled. The block is meant to sit beside a memory controller or a bus monitor as a protocol checker and command classifier.

Top module: `sdcmd_tracker`

## Requirements
- R1: Row strobe low with column strobe and write enable high (pins 0,1,1) is an activate: the addressed bank is shown open and `act_stb` is high for one cycle after that edge.
- R2: Row strobe high with column strobe low is a column command: write enable high (1,0,1) is a read and raises `rd_stb`, write enable low (1,0,0) is a write and raises `wr_stb`, each only when the command is legal.
- R3: Row strobe low, column strobe high, write enable low (0,1,0) is a precharge: it closes the addressed bank and raises `pre_stb`; a precharge to a closed bank is accepted and changes nothing else.
- R4: A read or write to a closed bank raises `err_closed` for one cycle, with no read or write strobe.
- R5: A column command sampled n rising edges after its bank's activate is legal when n is at least TRCD; otherwise `err_early` pulses for one cycle and no read or write strobe is given.
- R6: Row and column strobe low with write enable high (0,0,1) is an auto refresh: it raises `ref_stb` only while all banks are closed; with any bank open `err_ref` pulses and the row counter holds.
- R7: Each accepted refresh increments `ref_row` by one, wrapping from 2^ROW_W-1 to 0.
- R8: Banks are tracked independently: several may be open at once, each with its own delay timer, and column commands may alternate between open banks.
- R9: The encodings 1,1,1 (no operation), 1,1,0 and 0,0,0 produce no strobe, no error and no state change.
- R10: After a synchronous active-low reset all banks are closed, all strobes and errors are low, `cmd_bank` is 0 and `ref_row` is 0.
- R11: An activate to an already open bank keeps it open and restarts its delay timer.
- R12: `cmd_bank` shows, one cycle after each edge, the bank select sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W | Bank select of the command |
| act_stb | output | 1 | Accepted activate |
| rd_stb | output | 1 | Legal read |
| wr_stb | output | 1 | Legal write |
| pre_stb | output | 1 | Accepted precharge |
| ref_stb | output | 1 | Accepted auto refresh |
| err_closed | output | 1 | Column command to a closed bank |
| err_early | output | 1 | Column command before the row-to-column delay |
| err_ref | output | 1 | Refresh while a bank is open |
| cmd_bank | output | BANK_W | Bank select of the reported command |
| bank_open | output | NUM_BANKS | Open state per bank |
| ref_row | output | ROW_W | Internal refresh row counter |

## Verification
The bench builds the tracker with two banks, a row-to-column delay of 3 and a 5-bit refresh counter. The narrow counter lets a run of refreshes cross the wrap point in a few dozen cycles, and the short delay lets a sweep of activate-to-column gaps from one to five clocks on both banks cover both sides of the legality boundary for reads and writes. Every pin encoding is driven against both banks and each cycle is compared with an arithmetic model of bank state, timer age and row count.

// File: rtl/sdcmd_pkg.sv
// Shared command type for the SDRAM command tracker.
// Assumes: one command is sampled per rising clock edge.
package sdcmd_pkg;
    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_RD    = 3'd2,
        CMD_WR    = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_REF   = 3'd5,
        CMD_OTHER = 3'd6
    } cmd_e;
endpackage

// File: rtl/sdcmd_decode.sv
// Combinational decode of the three control strobes into a command class.
// Assumes: strobes are active low and already synchronous to the clock.
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    // Map the pin triple to a command class.
    always_comb begin
        unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b111:  cmd = CMD_NOP;
            default: cmd = CMD_OTHER;
        endcase
    end
endmodule

// File: rtl/sdcmd_bank_slot.sv
// Open/closed state and row-to-column delay timer for one bank.
// Assumes: act_hit and pre_hit are never high together; TRCD >= 1.
// ready_o rises once TRCD edges have passed since the last activate.
module sdcmd_bank_slot #(
    parameter int TRCD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_hit,
    input  logic pre_hit,
    output logic open_o,
    output logic ready_o
);
    localparam int CNT_W = $clog2(TRCD + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TRCD);

    logic             open_q;
    logic [CNT_W-1:0] cnt_q;

    // Track bank state and count edges since activate, saturating at TRCD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (act_hit) begin
            open_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
        end else if (pre_hit) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (open_q && cnt_q != CNT_MAX) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign open_o  = open_q;
    assign ready_o = open_q && (cnt_q == CNT_MAX);

    // R5: timer never passes its limit
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
    // R3: precharge closes the bank on the next edge
    a_r3_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && !act_hit) |=> !open_o);
    // R11: activate opens the bank and restarts the delay
    a_r11_act_restart: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit |=> (open_o && ((TRCD == 1) || !ready_o)));
endmodule

// File: rtl/sdcmd_ref_ctr.sv
// Refresh row counter: advances by one per accepted refresh and wraps.
// Assumes: adv is high only for refreshes that were accepted.
module sdcmd_ref_ctr #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] row_q;

    // Step the row on each accepted refresh, natural wrap at 2^ROW_W.
    always_ff @(posedge clk) begin
        if (!rst_n)   row_q <= '0;
        else if (adv) row_q <= row_q + ROW_W'(1);
    end

    assign row_o = row_q;

    // R7: row holds when no refresh is accepted
    a_r7_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(row_o));
endmodule

// File: rtl/sdcmd_tracker.sv
// SDRAM command decoder and bank tracker (top).
// Classifies each sampled command, keeps per-bank open state and delay
// timers, gates column commands and refreshes, and registers the strobes.
// Assumes: one command per edge; bank selects beyond NUM_BANKS are closed.
module sdcmd_tracker
    import sdcmd_pkg::*;
#(
    parameter  int NUM_BANKS = 2,
    parameter  int TRCD      = 3,
    parameter  int ROW_W     = 12,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BANK_W-1:0]    bank,
    output logic                 act_stb,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic                 pre_stb,
    output logic                 ref_stb,
    output logic                 err_closed,
    output logic                 err_early,
    output logic                 err_ref,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [ROW_W-1:0]     ref_row
);
    cmd_e                 cmd;
    logic                 bank_ok;
    logic [NUM_BANKS-1:0] open_vec;
    logic [NUM_BANKS-1:0] ready_vec;
    logic                 sel_open;
    logic                 sel_ready;
    logic                 is_col;
    logic                 col_ok;
    logic                 ref_ok;

    sdcmd_decode u_dec (
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign bank_ok = (32'(bank) < NUM_BANKS);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_slot
        sdcmd_bank_slot #(.TRCD(TRCD)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_hit ((cmd == CMD_ACT) && bank_ok && (32'(bank) == g)),
            .pre_hit ((cmd == CMD_PRE) && bank_ok && (32'(bank) == g)),
            .open_o  (open_vec[g]),
            .ready_o (ready_vec[g])
        );
    end

    // Select the state of the addressed bank and judge legality.
    always_comb begin
        sel_open  = 1'b0;
        sel_ready = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (32'(bank) == i) begin
                sel_open  = open_vec[i];
                sel_ready = ready_vec[i];
            end
        end
        is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
        col_ok = is_col && sel_open && sel_ready;
        ref_ok = (cmd == CMD_REF) && (open_vec == '0);
    end

    sdcmd_ref_ctr #(.ROW_W(ROW_W)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ref_ok),
        .row_o (ref_row)
    );

    // Register the strobes, error pulses and the sampled bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_stb    <= 1'b0;
            rd_stb     <= 1'b0;
            wr_stb     <= 1'b0;
            pre_stb    <= 1'b0;
            ref_stb    <= 1'b0;
            err_closed <= 1'b0;
            err_early  <= 1'b0;
            err_ref    <= 1'b0;
            cmd_bank   <= '0;
        end else begin
            act_stb    <= (cmd == CMD_ACT);
            rd_stb     <= col_ok && (cmd == CMD_RD);
            wr_stb     <= col_ok && (cmd == CMD_WR);
            pre_stb    <= (cmd == CMD_PRE);
            ref_stb    <= ref_ok;
            err_closed <= is_col && !sel_open;
            err_early  <= is_col && sel_open && !sel_ready;
            err_ref    <= (cmd == CMD_REF) && (open_vec != '0);
            cmd_bank   <= bank;
        end
    end

    assign bank_open = open_vec;

    // R2: at most one strobe or error per cycle
    a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_stb, rd_stb, wr_stb, pre_stb, ref_stb,
                  err_closed, err_early, err_ref}));
    // R6: an accepted refresh saw every bank closed
    a_r6_ref_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |-> ($past(bank_open) == '0));
    // R4: a legal column strobe saw its bank open
    a_r4_col_open: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |->
            ((($past(bank_open) >> cmd_bank) & NUM_BANKS'(1)) != '0));
    // R7: accepted refresh advances the row by one
    a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |-> (ref_row == ROW_W'($past(ref_row) + ROW_W'(1))));
endmodule

// File: tb/sim_sdcmd_tracker.sv
module sim_sdcmd_tracker;
    localparam int NB = 2;
    localparam int TD = 3;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [0:0] bank = '0;
    logic act_stb, rd_stb, wr_stb, pre_stb, ref_stb;
    logic err_closed, err_early, err_ref;
    logic [0:0] cmd_bank;
    logic [NB-1:0] bank_open;
    logic [RW-1:0] ref_row;

    int checks = 0;
    int failures = 0;
    bit mopen [NB];
    int age [NB];
    int mrow = 0;

    always #10 clk = ~clk;

    sdcmd_tracker #(.NUM_BANKS(NB), .TRCD(TD), .ROW_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank(bank), .act_stb(act_stb), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .pre_stb(pre_stb), .ref_stb(ref_stb), .err_closed(err_closed),
        .err_early(err_early), .err_ref(err_ref), .cmd_bank(cmd_bank),
        .bank_open(bank_open), .ref_row(ref_row)
    );

    task automatic compare(input string tag, input logic [7:0] ev, input int eb);
        logic [7:0] av;
        logic [NB-1:0] eo;
        av = {act_stb, rd_stb, wr_stb, pre_stb, ref_stb, err_closed, err_early, err_ref};
        for (int i = 0; i < NB; i++) eo[i] = mopen[i];
        checks++;
        if (av !== ev || cmd_bank !== 1'(eb) || bank_open !== eo || ref_row !== RW'(mrow)) begin
            failures++;
            $display("FAIL %s: act ev=%b bank=%0d open=%b row=%0d exp ev=%b bank=%0d open=%b row=%0d",
                     tag, av, cmd_bank, bank_open, ref_row, ev, eb, eo, mrow);
        end
    endtask

    // Drive one command, advance the model, check after the edge.
    task automatic step(input logic r, input logic c, input logic w, input int b, input string tag);
        logic [7:0] ev;
        bit anyopen;
        ev = '0;
        anyopen = 1'b0;
        for (int i = 0; i < NB; i++) if (mopen[i]) anyopen = 1'b1;
        ras_n = r; cas_n = c; we_n = w; bank = 1'(b);
        case ({r, c, w})
            3'b011: ev[7] = 1'b1;
            3'b101, 3'b100: begin
                if (!mopen[b])      ev[2] = 1'b1;
                else if (age[b] < TD) ev[1] = 1'b1;
                else if (w)         ev[6] = 1'b1;
                else                ev[5] = 1'b1;
            end
            3'b010: ev[4] = 1'b1;
            3'b001: begin
                if (anyopen) ev[0] = 1'b1;
                else begin ev[3] = 1'b1; mrow = (mrow + 1) % (1 << RW); end
            end
            default: ;
        endcase
        if ({r, c, w} == 3'b011) begin mopen[b] = 1'b1; age[b] = 0; end
        if ({r, c, w} == 3'b010) mopen[b] = 1'b0;
        for (int i = 0; i < NB; i++) if (age[i] < 1000) age[i]++;
        @(posedge clk);
        #1;
        compare(tag, ev, b);
        @(negedge clk);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b1, 0, "R9 nop");
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) begin mopen[i] = 1'b0; age[i] = 1000; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare("R10 reset", 8'h00, 0);
        @(negedge clk);
        // R9: untracked encodings on both banks
        for (int b = 0; b < NB; b++) begin
            step(1'b1, 1'b1, 1'b1, b, "R9 nop enc");
            step(1'b1, 1'b1, 1'b0, b, "R9 enc 110");
            step(1'b0, 1'b0, 1'b0, b, "R9 enc 000");
        end
        // R4: column commands to closed banks
        for (int b = 0; b < NB; b++) begin
            step(1'b1, 1'b0, 1'b1, b, "R4 read closed");
            step(1'b1, 1'b0, 1'b0, b, "R4 write closed");
        end
        // R5/R1/R2/R12: sweep of activate-to-column gap
        for (int b = 0; b < NB; b++) begin
            for (int d = 1; d <= 5; d++) begin
                step(1'b0, 1'b1, 1'b1, b, "R1 activate");
                nop(d - 1);
                step(1'b1, 1'b0, (d % 2) ? 1'b1 : 1'b0, b, "R5 R2 column gap");
                step(1'b1, 1'b0, 1'b1, b, "R2 read again");
                step(1'b0, 1'b1, 1'b0, b, "R3 precharge");
            end
        end
        // R3: precharge of a closed bank
        step(1'b0, 1'b1, 1'b0, 1, "R3 precharge closed");
        // R11: reactivate restarts the timer
        step(1'b0, 1'b1, 1'b1, 0, "R11 act");
        nop(2);
        step(1'b0, 1'b1, 1'b1, 0, "R11 reactivate");
        step(1'b1, 1'b0, 1'b1, 0, "R11 early after restart");
        nop(1);
        step(1'b1, 1'b0, 1'b1, 0, "R11 ready after restart");
        // R8: two open banks with independent timers
        step(1'b0, 1'b1, 1'b1, 1, "R8 act bank1");
        step(1'b1, 1'b0, 1'b0, 0, "R8 write bank0");
        step(1'b1, 1'b0, 1'b1, 1, "R8 early bank1");
        step(1'b1, 1'b0, 1'b1, 1, "R8 read bank1");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, i[0], i % 2, "R8 alternate");
        // R6: refresh blocked while banks open
        step(1'b0, 1'b0, 1'b1, 0, "R6 ref both open");
        step(1'b0, 1'b1, 1'b0, 0, "R3 close bank0");
        step(1'b0, 1'b0, 1'b1, 1, "R6 ref one open");
        step(1'b0, 1'b1, 1'b0, 1, "R3 close bank1");
        // R7: refresh run across the wrap
        for (int i = 0; i < (1 << RW) + 3; i++) step(1'b0, 1'b0, 1'b1, i % 2, "R7 R6 refresh");
        step(1'b0, 1'b1, 1'b1, 0, "R1 act after refresh");
        step(1'b0, 1'b0, 1'b1, 0, "R6 ref blocked");
        // R10: reset in mid operation
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < NB; i++) begin mopen[i] = 1'b0; age[i] = 1000; end
        mrow = 0;
        compare("R10 reset again", 8'h00, 0);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule